// File: doc/BRIEF.md
# Control-Bus Target with Gated Tuner Branch

This block answers on a two-wire open-drain control bus as a target with a 7-bit address and holds a small bank of byte registers. A controller first writes a pointer byte, then writes further bytes into successive registers, or issues a repeated start and reads successive registers back. The block samples both bus lines with its own fast system clock, so it needs no clock derived from the bus.

Bit 0 of register 0 opens a gate onto a second open-drain branch meant for a tuner. While the gate is open, the branch clock copies the controller's clock, and the data line is bridged in both directions: a low on either side is repeated on the other. While the gate is closed, both branch lines are released. A new gate setting takes effect only after the bus has gone idle, so the branch never sees a partial transaction. Every line is open drain: each output is a pull-low enable, and a released line floats high through an external pull-up.

Top module: `i2c_tgate`

## Requirements
- R1: After reset, all three pull-low outputs are inactive, and every register reads as 0x00. The gate is closed.
- R2: The target acknowledges an address byte by pulling SDA low during the ninth clock only when the upper seven bits equal binary 00010 followed by addr_sel_i[1:0]. Bit 0 of the address byte selects read when it is 1. Any other address gets no acknowledge.
- R3: In a write, the first byte after the address sets the register pointer, taken as the pointer byte modulo the register count (its low two bits with four registers). Each further byte is stored at the pointer, and the pointer then advances, wrapping from the last register to register 0.
- R4: In a read, the target sends the register at the pointer, most significant bit first, and the pointer advances after each byte. It keeps sending successive registers while the controller acknowledges, and stops after a not-acknowledge.
- R5: Every byte written after a matched address, the pointer byte included, is acknowledged by SDA low during the ninth clock.
- R6: With the gate open, the tuner clock output pulls low while the controller's SCL is low and releases while it is high.
- R7: With the gate closed, both tuner outputs stay released, and a low driven on the tuner data line does not reach the controller's SDA.
- R8: A write to bit 0 of register 0 changes the gate only once a stop has ended the transaction. Before the stop, the tuner lines keep their previous behaviour.
- R9: With the gate open, a low driven by the controller on SDA is repeated onto the tuner data line, and a low driven by a tuner device, such as its acknowledge, is repeated onto the controller's SDA.
- R10: A repeated start restarts address decoding, so that a pointer write followed by a repeated start and a read address returns data from the new pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, far faster than the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Level sensed on the controller bus clock line |
| sda_i | input | 1 | Level sensed on the controller bus data line |
| addr_sel_i | input | 2 | Strap pins forming the two low bits of the target address |
| tun_sda_i | input | 1 | Level sensed on the tuner branch data line |
| sda_oe_o | output | 1 | Pull-low enable for the controller data line |
| tun_scl_oe_o | output | 1 | Pull-low enable for the tuner branch clock line |
| tun_sda_oe_o | output | 1 | Pull-low enable for the tuner branch data line |

## Verification
The address decoder is swept across all four strap settings against the four matching-prefix addresses and two foreign ones. This separates a correct compare from one that ignores the strap bits or the fixed prefix. Multi-byte writes with a pointer byte whose upper bits are set, followed by reads that start at different offsets, separate correct pointer masking, increment and wrap-around from an off-by-one or a stuck pointer. The tuner gate is exercised while closed, while a write that opens it is still in progress, while open with controller-driven and tuner-driven lows, and after it is closed again. Together these show both bridge directions, deferral of the gate to the stop, and isolation when closed.

// File: rtl/i2c_tgate_pkg.sv
`timescale 1ns/1ps
package i2c_tgate_pkg;
  localparam int BYTE_W = 8;
  localparam logic [4:0] DEV_PREFIX = 5'b00010;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_PTR, ST_PACK,
    ST_WDAT, ST_WACK, ST_RDAT, ST_RACK
  } slv_state_e;
endpackage

// File: rtl/i2c_tgate_sync.sv
`timescale 1ns/1ps
module i2c_tgate_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  // bus lines idle high, so the pipeline resets to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '1;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_tgate_slave.sv
`timescale 1ns/1ps
module i2c_tgate_slave
  import i2c_tgate_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic [1:0] addr_sel,
  output logic       sda_oe,
  output logic       busy,
  output logic       gate_req
);
  localparam int PW = (NREG > 1) ? $clog2(NREG) : 1;

  logic              scl_d, sda_d;
  slv_state_e        state_q, state_n;
  logic [3:0]        cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n, tx_q, tx_n;
  logic [PW-1:0]     ptr_q, ptr_n;
  logic              rw_q, rw_n, nack_q, nack_n, oe_q, oe_n, busy_q, busy_n;
  logic              wr_en;
  logic [BYTE_W-1:0] regs_q [NREG];

  logic scl_rise, scl_fall, start_det, stop_det, rx_state;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign rx_state  = (state_q == ST_ADDR) || (state_q == ST_PTR) || (state_q == ST_WDAT);

  always_comb begin
    state_n = state_q; cnt_n = cnt_q; sh_n = sh_q; tx_n = tx_q;
    ptr_n = ptr_q; rw_n = rw_q; nack_n = nack_q; oe_n = oe_q;
    busy_n = busy_q; wr_en = 1'b0;
    if (start_det) begin
      state_n = ST_ADDR; cnt_n = 4'd0; oe_n = 1'b0; busy_n = 1'b1;
    end else if (stop_det) begin
      state_n = ST_IDLE; oe_n = 1'b0; busy_n = 1'b0;
    end else if (scl_rise) begin
      if (rx_state) begin
        sh_n  = {sh_q[BYTE_W-2:0], sda_s};
        cnt_n = cnt_q + 4'd1;
      end
      if (state_q == ST_RDAT) cnt_n = cnt_q + 4'd1;
      if (state_q == ST_RACK) nack_n = sda_s;
    end else if (scl_fall) begin
      unique case (state_q)
        ST_ADDR: if (cnt_q == 4'd8) begin
          if (sh_q[7:1] == {DEV_PREFIX, addr_sel}) begin
            state_n = ST_AACK; oe_n = 1'b1; rw_n = sh_q[0];
          end else begin
            state_n = ST_IDLE;
          end
        end
        ST_AACK: begin
          cnt_n = 4'd0;
          if (rw_q) begin
            state_n = ST_RDAT; tx_n = regs_q[ptr_q]; oe_n = ~regs_q[ptr_q][7];
          end else begin
            state_n = ST_PTR; oe_n = 1'b0;
          end
        end
        ST_PTR: if (cnt_q == 4'd8) begin
          ptr_n = sh_q[PW-1:0]; state_n = ST_PACK; oe_n = 1'b1;
        end
        ST_PACK, ST_WACK: begin
          oe_n = 1'b0; cnt_n = 4'd0; state_n = ST_WDAT;
        end
        ST_WDAT: if (cnt_q == 4'd8) begin
          wr_en = 1'b1; ptr_n = ptr_q + PW'(1); state_n = ST_WACK; oe_n = 1'b1;
        end
        ST_RDAT: begin
          if (cnt_q == 4'd8) begin
            oe_n = 1'b0; state_n = ST_RACK; ptr_n = ptr_q + PW'(1);
          end else begin
            tx_n = {tx_q[6:0], tx_q[7]}; oe_n = ~tx_q[6];
          end
        end
        ST_RACK: begin
          if (nack_q) begin
            state_n = ST_IDLE;
          end else begin
            state_n = ST_RDAT; cnt_n = 4'd0;
            tx_n = regs_q[ptr_q]; oe_n = ~regs_q[ptr_q][7];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1; sda_d <= 1'b1;
      state_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; tx_q <= '0; ptr_q <= '0;
      rw_q <= 1'b0; nack_q <= 1'b0; oe_q <= 1'b0; busy_q <= 1'b0;
    end else begin
      scl_d <= scl_s; sda_d <= sda_s;
      state_q <= state_n; cnt_q <= cnt_n; sh_q <= sh_n; tx_q <= tx_n; ptr_q <= ptr_n;
      rw_q <= rw_n; nack_q <= nack_n; oe_q <= oe_n; busy_q <= busy_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      regs_q[ptr_q] <= sh_q;
    end
  end

  assign sda_oe   = oe_q;
  assign busy     = busy_q;
  assign gate_req = regs_q[0][0];

  // R5
  ack_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !scl_s);
  // R2
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= 4'd8);
  // R4
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !oe_q);
endmodule

// File: rtl/i2c_tgate_bridge.sv
`timescale 1ns/1ps
module i2c_tgate_bridge #(
  parameter int GUARD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_req,
  input  logic busy,
  input  logic scl_s,
  input  logic sda_s,
  input  logic tsda_s,
  output logic tun_scl_oe,
  output logic tun_sda_oe,
  output logic msda_oe
);
  localparam int GW = $clog2(GUARD + 1);

  logic          gate_q, gate_en;
  logic          scl_oe_q, scl_oe_n;
  logic          m2t_q, m2t_n, t2m_q, t2m_n;
  logic [GW-1:0] guard_q, guard_n;
  logic          quiet;

  assign gate_en = ~busy;
  assign quiet   = (guard_q == '0);

  always_comb begin
    scl_oe_n = gate_q & ~scl_s;
    m2t_n    = gate_q & ~sda_s & ~t2m_q & (quiet | m2t_q);
    t2m_n    = gate_q & ~tsda_s & ~m2t_q & ~m2t_n & (quiet | t2m_q);
    if ((m2t_q & ~m2t_n) | (t2m_q & ~t2m_n)) guard_n = GW'(GUARD);
    else if (!quiet)                        guard_n = guard_q - GW'(1);
    else                                    guard_n = guard_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0; scl_oe_q <= 1'b0; m2t_q <= 1'b0; t2m_q <= 1'b0; guard_q <= '0;
    end else begin
      if (gate_en) gate_q <= gate_req;
      scl_oe_q <= scl_oe_n; m2t_q <= m2t_n; t2m_q <= t2m_n; guard_q <= guard_n;
    end
  end

  assign tun_scl_oe = scl_oe_q;
  assign tun_sda_oe = m2t_q;
  assign msda_oe    = t2m_q;

  // R9
  one_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(m2t_q && t2m_q));
  // R7
  closed_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_q |=> (!tun_scl_oe && !tun_sda_oe && !msda_oe));
  // R8
  gate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_q) |-> !$past(busy));
endmodule

// File: rtl/i2c_tgate.sv
`timescale 1ns/1ps
module i2c_tgate #(
  parameter int NREG   = 4,
  parameter int STAGES = 2,
  parameter int GUARD  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] addr_sel_i,
  input  logic       tun_sda_i,
  output logic       sda_oe_o,
  output logic       tun_scl_oe_o,
  output logic       tun_sda_oe_o
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  logic       scl_s, sda_s, tsda_s;
  logic       slv_oe, busy, gate_req, msda_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  i2c_tgate_sync #(.W(3), .STAGES(STAGES)) sync_i (
    .clk(clk), .rst_n(rst_int_n),
    .d_i({scl_i, sda_i, tun_sda_i}), .q_o({scl_s, sda_s, tsda_s})
  );

  i2c_tgate_slave #(.NREG(NREG)) slave_i (
    .clk(clk), .rst_n(rst_int_n), .scl_s(scl_s), .sda_s(sda_s),
    .addr_sel(addr_sel_i), .sda_oe(slv_oe), .busy(busy), .gate_req(gate_req)
  );

  i2c_tgate_bridge #(.GUARD(GUARD)) bridge_i (
    .clk(clk), .rst_n(rst_int_n), .gate_req(gate_req), .busy(busy),
    .scl_s(scl_s), .sda_s(sda_s), .tsda_s(tsda_s),
    .tun_scl_oe(tun_scl_oe_o), .tun_sda_oe(tun_sda_oe_o), .msda_oe(msda_oe)
  );

  assign sda_oe_o = slv_oe | msda_oe;
endmodule

// File: tb/i2c_tgate_tb.sv
`timescale 1ns/1ps
module i2c_tgate_tb_top;
  localparam int Q = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic m_scl_lo, m_sda_lo, dev_lo;
  logic [1:0] sel;
  logic sda_oe, tun_scl_oe, tun_sda_oe;
  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] wbuf [8];
  logic [7:0] exp_reg [4];

  wire scl_line     = ~m_scl_lo;
  wire sda_line     = ~(m_sda_lo | sda_oe);
  wire tun_scl_line = ~tun_scl_oe;
  wire tun_sda_line = ~(tun_sda_oe | dev_lo);

  always #2.5 clk = ~clk;

  i2c_tgate dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .addr_sel_i(sel), .tun_sda_i(tun_sda_line),
    .sda_oe_o(sda_oe), .tun_scl_oe_o(tun_scl_oe), .tun_sda_oe_o(tun_sda_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic bstart();
    m_sda_lo = 1'b0; tick(Q);
    m_scl_lo = 1'b0; tick(Q);
    m_sda_lo = 1'b1; tick(Q);
    m_scl_lo = 1'b1; tick(Q);
  endtask

  task automatic bstop();
    m_sda_lo = 1'b1; tick(Q);
    m_scl_lo = 1'b0; tick(Q);
    m_sda_lo = 1'b0; tick(Q);
  endtask

  task automatic wbit(input logic b);
    m_sda_lo = ~b; tick(Q);
    m_scl_lo = 1'b0; tick(2*Q);
    m_scl_lo = 1'b1; tick(Q);
  endtask

  task automatic rbit(output logic b);
    m_sda_lo = 1'b0; tick(Q);
    m_scl_lo = 1'b0; tick(Q);
    b = sda_line; tick(Q);
    m_scl_lo = 1'b1; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(a);
    ack = ~a;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    wbit(~give_ack);
  endtask

  function automatic logic [7:0] dev_w();
    return {5'b00010, sel, 1'b0};
  endfunction

  task automatic write_regs(input logic [7:0] ptr, input int n, input bit do_stop);
    logic a;
    bstart();
    wbyte(dev_w(), a); chk(a, "R2 address ack on write", a, 1);
    wbyte(ptr, a);     chk(a, "R5 pointer byte ack", a, 1);
    for (int k = 0; k < n; k++) begin
      wbyte(wbuf[k], a); chk(a, "R5 data byte ack", a, 1);
      exp_reg[(ptr[1:0] + k) % 4] = wbuf[k];
    end
    if (do_stop) bstop();
  endtask

  task automatic read_regs(input logic [7:0] ptr, input int n);
    logic a;
    logic [7:0] d;
    bstart();
    wbyte(dev_w(), a); chk(a, "R2 address ack before read", a, 1);
    wbyte(ptr, a);     chk(a, "R5 pointer ack before read", a, 1);
    bstart();
    wbyte(dev_w() | 8'h01, a); chk(a, "R10 read address ack after repeated start", a, 1);
    for (int k = 0; k < n; k++) begin
      rbyte(k != n - 1, d);
      chk(d == exp_reg[(ptr[1:0] + k) % 4], "R4 read data", d, exp_reg[(ptr[1:0] + k) % 4]);
    end
    bstop();
  endtask

  initial begin
    logic a;
    rst_n = 1'b0; m_scl_lo = 1'b0; m_sda_lo = 1'b0; dev_lo = 1'b0; sel = 2'd0;
    for (int i = 0; i < 4; i++) exp_reg[i] = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(10);

    // R1 reset state
    chk(!sda_oe && !tun_scl_oe && !tun_sda_oe, "R1 outputs released",
        {sda_oe, tun_scl_oe, tun_sda_oe}, 0);
    read_regs(8'h00, 4);

    // R2 address sweep over straps and candidates
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      for (int c = 0; c < 6; c++) begin
        logic [6:0] cand;
        cand = (c < 4) ? 7'(8 + c) : ((c == 4) ? 7'h18 : 7'h48);
        bstart();
        wbyte({cand, 1'b0}, a);
        chk(a == (cand == 7'(8 + s)), "R2 address decode", {cand, a}, {7'(8 + s), 1'b1});
        bstop();
      end
    end
    sel = 2'd2;

    // R3 burst write with masked pointer and wrap
    wbuf[0] = 8'h5A; wbuf[1] = 8'hC3; wbuf[2] = 8'h3C; wbuf[3] = 8'h96;
    write_regs(8'h06, 4, 1);
    chk(exp_reg[0] == 8'h3C && exp_reg[2] == 8'h5A, "R3 model", exp_reg[0], 8'h3C);
    read_regs(8'h00, 4);
    read_regs(8'h03, 2);
    for (int p = 0; p < 4; p++) begin
      wbuf[0] = 8'(8'h40 + p * 8'h24);
      write_regs(8'(p), 1, 1);
    end
    read_regs(8'h01, 4);

    // R10 repeated start with a foreign address gets no ack
    bstart();
    wbyte(dev_w(), a);
    wbyte(8'h00, a);
    bstart();
    wbyte(8'hC1, a); chk(!a, "R10 foreign address after repeated start", a, 0);
    bstop();

    // R8 open the gate: no effect before the stop
    wbuf[0] = 8'h41;
    write_regs(8'h00, 1, 0);
    tick(4);
    chk(tun_scl_line == 1'b1, "R8 tuner clock still released before stop", tun_scl_line, 1);
    bstop();
    bstart();
    chk(tun_scl_line == 1'b0, "R8 gate open after stop, R6 clock low", tun_scl_line, 0);

    // R6 and R9 clock follow and master-to-tuner data, tuner ack back
    for (int i = 7; i >= 0; i--) begin
      logic b;
      b = 8'hC0 >> i;
      m_sda_lo = ~b; tick(Q);
      chk(tun_sda_line == b, "R9 master data reaches tuner", tun_sda_line, b);
      chk(tun_scl_line == 1'b0, "R6 tuner clock low", tun_scl_line, 0);
      m_scl_lo = 1'b0; tick(Q);
      chk(tun_scl_line == 1'b1, "R6 tuner clock high", tun_scl_line, 1);
      tick(Q);
      m_scl_lo = 1'b1; tick(Q);
    end
    dev_lo = 1'b1;
    rbit(a);
    dev_lo = 1'b0;
    chk(a == 1'b0, "R9 tuner ack reaches master", a, 0);
    bstop();

    // close the gate
    wbuf[0] = 8'h40;
    write_regs(8'h00, 1, 1);

    // R7 closed gate isolates the branch
    bstart();
    chk(tun_scl_line && tun_sda_line, "R7 branch released", {tun_scl_line, tun_sda_line}, 3);
    for (int i = 7; i >= 0; i--) wbit(1'(8'hC0 >> i));
    dev_lo = 1'b1;
    rbit(a);
    dev_lo = 1'b0;
    chk(a == 1'b1, "R7 tuner low blocked", a, 1);
    bstop();
    read_regs(8'h00, 4);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule